// File: doc/BRIEF.md
# SPI Register Access Slave

This block connects a host microcontroller to a bank of on-chip registers over a four-wire serial link. The four wires are serial clock, active-low chip select, serial data in and serial data out. The block runs on the chip's system clock. It brings the serial signals into that clock domain through two-flop synchronizers and detects the rising edges of the serial clock there. For this to work, each serial clock phase must last at least four system clocks.

Every access opens with an 8-bit header, sent most significant bit first:

- the register/RAM select bit, which must be 0;
- the direction bit;
- a 6-bit address.

What follows the header depends on the address:

- A 16-bit register takes 16 data bits.
- A FIFO port takes 8 data bits.
- A command strobe takes nothing more and fires a one-cycle pulse.

Accesses may be chained inside one chip-select period. The block drives:

- a register-file write port;
- a read address toward the register file, which answers combinationally;
- a one-hot strobe vector;
- push and pop handshakes for the transmit and receive FIFOs.

Top module: `spiRegSlave`

## Requirements
- R1: The header is sampled on serial clock rising edges, MSB first: bit 7 selects RAM (1) or register space (0), bit 6 is the direction (0 write, 1 read), bits 5..0 are the address with bit 5 first.
- R2: A write to a register address (0x10 to 0x30) gives exactly one `regWrEn` pulse, one system clock wide, after the 16th data bit (D15 first) has been sampled, with `regAddr` and `regWrData` holding the address and word.
- R3: A read of a register address shifts the `regRdData` word for that address out on `sdo`, D15 first, with each bit valid at the 16 serial clock rising edges following the header.
- R4: Addresses 0x00 to 0x0E are command strobes: after the 8-bit header, either direction, one `cmdStrobe` bit (index equal to the address) pulses for one system clock, and the next serial bit starts a new header.
- R5: A write to address 0x3E carries 8 data bits and gives one `txPush` pulse with `txData` equal to the received byte.
- R6: A read of address 0x3F gives one `rxPop` pulse and shifts out the `rxData` byte present at the end of the header, MSB first, over the next 8 serial clocks.
- R7: While chip select stays low, a new header begins on the serial clock right after the previous access's last bit.
- R8: Raising chip select before the last bit of an access commits nothing (no `regWrEn`, no `txPush`); the next chip-select period starts with a fresh header.
- R9: `sdoOe` is low once chip select has been high for three system clocks and high once it has been low for three system clocks, and is low out of reset.
- R10: A header with bit 7 set makes the block ignore all remaining bits until chip select rises: no write, strobe, push or pop.
- R11: Address 0x0F and 0x31 to 0x3D take 16 data bits, never raise `regWrEn`, and read back zeros; reading 0x3E or writing 0x3F takes 8 bits, reads back zeros, and gives no pop or push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Output enable for the sdo pad driver |
| regAddr | output | 6 | Register address of the current access |
| regWrEn | output | 1 | Register write pulse |
| regWrData | output | 16 | Register write word |
| regRdData | input | 16 | Register word for regAddr |
| cmdStrobe | output | 15 | One-hot command strobe pulses |
| txPush | output | 1 | Transmit FIFO push pulse |
| txData | output | 8 | Byte pushed to the transmit FIFO |
| rxPop | output | 1 | Receive FIFO pop pulse |
| rxData | input | 8 | Head byte of the receive FIFO |

## Verification
Single accesses separate the register, strobe and FIFO paths. Each address class is tried in both directions, so that a misdecoded kind or an inverted direction bit shows up as a wrong or missing event.

A long chain inside one chip-select period mixes 16-bit, 8-bit and header-only accesses. This exposes any bit-count error, because a miscount shifts every later header.

Three further patterns target stray commits:
- a frame cut short, followed by a read of the same register, checks that nothing was written;
- a RAM-space header followed by a valid-looking write checks that the rest of the frame is ignored;
- writes and reads at the unused addresses check that they have no effect.

Read data is compared bit by bit at each serial rising edge against a bench register image.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  parameter int ADDR_W     = 6;
  parameter int HDR_W      = 8;
  parameter int REG_W      = 16;
  parameter int FIFO_W     = 8;
  parameter int NUM_STROBE = 15;
  parameter int REG_BASE   = 16;
  parameter int NUM_REGS   = 33;
  parameter int TX_ADDR    = 62;
  parameter int RX_ADDR    = 63;
  localparam int CNT_W     = $clog2(REG_W);

  typedef enum logic [2:0] {K_STROBE, K_REG, K_TXF, K_RXF, K_NONE} kindT;
  typedef enum logic [1:0] {LD_ZERO, LD_REG, LD_RX} loadT;

  typedef struct packed {
    logic hdrShift;
    logic datShift;
    logic load;
    loadT loadSel;
    logic clrOut;
    logic regWe;
    logic push;
    logic pop;
    logic strobe;
  } ctlT;

  function automatic kindT decodeKind(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a);
    if (v < NUM_STROBE) return K_STROBE;
    if (v >= REG_BASE && v < REG_BASE + NUM_REGS) return K_REG;
    if (v == TX_ADDR) return K_TXF;
    if (v == RX_ADDR) return K_RXF;
    return K_NONE;
  endfunction
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csActive,
  input  logic             sclkRise,
  input  logic [HDR_W-1:0] hdr,
  output ctlT              ctl
);
  typedef enum logic [2:0] {S_HDR, S_DEC, S_DATA, S_COMMIT, S_SKIP} stateT;

  stateT            state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastIdx;
  kindT             kind;
  logic             isWrite;
  kindT             hdrKind;
  logic             hdrRead;
  logic             ramSel;

  assign hdrKind = decodeKind(hdr[ADDR_W-1:0]);
  assign hdrRead = hdr[HDR_W-2];
  assign ramSel  = hdr[HDR_W-1];

  always_comb begin
    ctl = '0;
    if (!csActive) begin
      ctl.clrOut = 1'b1;
    end else begin
      unique case (state)
        S_HDR:  ctl.hdrShift = sclkRise;
        S_DEC: if (!ramSel) begin
          ctl.load = 1'b1;
          if (hdrKind == K_REG && hdrRead)      ctl.loadSel = LD_REG;
          else if (hdrKind == K_RXF && hdrRead) ctl.loadSel = LD_RX;
          else                                  ctl.loadSel = LD_ZERO;
          ctl.pop    = (hdrKind == K_RXF) && hdrRead;
          ctl.strobe = (hdrKind == K_STROBE);
        end
        S_DATA: ctl.datShift = sclkRise;
        S_COMMIT: begin
          ctl.regWe = (kind == K_REG) && isWrite;
          ctl.push  = (kind == K_TXF) && isWrite;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_HDR;
      cnt     <= '0;
      lastIdx <= '0;
      kind    <= K_NONE;
      isWrite <= 1'b0;
    end else if (!csActive) begin
      state <= S_HDR;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_HDR: if (sclkRise) begin
          if (cnt == CNT_W'(HDR_W - 1)) begin
            cnt   <= '0;
            state <= S_DEC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DEC: begin
          kind    <= hdrKind;
          isWrite <= ~hdrRead;
          lastIdx <= (hdrKind == K_TXF || hdrKind == K_RXF) ?
                     CNT_W'(FIFO_W - 1) : CNT_W'(REG_W - 1);
          if (ramSel)                    state <= S_SKIP;
          else if (hdrKind == K_STROBE)  state <= S_HDR;
          else                           state <= S_DATA;
        end
        S_DATA: if (sclkRise) begin
          if (cnt == lastIdx) begin
            cnt   <= '0;
            state <= S_COMMIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_COMMIT: state <= S_HDR;
        default:  state <= S_SKIP;
      endcase
    end
  end
endmodule

// File: rtl/spiRegDp.sv
module spiRegDp
  import spiRegPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlT                   ctl,
  input  logic                  sdiS,
  input  logic [REG_W-1:0]      regRdData,
  input  logic [FIFO_W-1:0]     rxData,
  output logic [HDR_W-1:0]      hdr,
  output logic                  sdo,
  output logic [ADDR_W-1:0]     regAddr,
  output logic                  regWrEn,
  output logic [REG_W-1:0]      regWrData,
  output logic [NUM_STROBE-1:0] cmdStrobe,
  output logic                  txPush,
  output logic [FIFO_W-1:0]     txData,
  output logic                  rxPop
);
  logic [HDR_W-1:0]      hdrSr;
  logic [REG_W-1:0]      datSr;
  logic [REG_W-1:0]      outSr;
  logic [NUM_STROBE-1:0] strobeNext;

  for (genvar i = 0; i < NUM_STROBE; i++) begin : gStrobe
    assign strobeNext[i] = ctl.strobe && (hdrSr[ADDR_W-1:0] == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrSr     <= '0;
      datSr     <= '0;
      outSr     <= '0;
      regWrEn   <= 1'b0;
      txPush    <= 1'b0;
      rxPop     <= 1'b0;
      cmdStrobe <= '0;
    end else begin
      if (ctl.hdrShift) hdrSr <= {hdrSr[HDR_W-2:0], sdiS};
      if (ctl.datShift) datSr <= {datSr[REG_W-2:0], sdiS};
      if (ctl.clrOut) begin
        outSr <= '0;
      end else if (ctl.load) begin
        unique case (ctl.loadSel)
          LD_REG:  outSr <= regRdData;
          LD_RX:   outSr <= {rxData, {(REG_W-FIFO_W){1'b0}}};
          default: outSr <= '0;
        endcase
      end else if (ctl.datShift) begin
        outSr <= {outSr[REG_W-2:0], 1'b0};
      end
      regWrEn   <= ctl.regWe;
      txPush    <= ctl.push;
      rxPop     <= ctl.pop;
      cmdStrobe <= strobeNext;
    end
  end

  assign hdr       = hdrSr;
  assign sdo       = outSr[REG_W-1];
  assign regAddr   = hdrSr[ADDR_W-1:0];
  assign regWrData = datSr;
  assign txData    = datSr[FIFO_W-1:0];
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spiRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclk,
  input  logic                  csN,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdoOe,
  output logic [ADDR_W-1:0]     regAddr,
  output logic                  regWrEn,
  output logic [REG_W-1:0]      regWrData,
  input  logic [REG_W-1:0]      regRdData,
  output logic [NUM_STROBE-1:0] cmdStrobe,
  output logic                  txPush,
  output logic [FIFO_W-1:0]     txData,
  output logic                  rxPop,
  input  logic [FIFO_W-1:0]     rxData
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b010;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] syncOut;
  logic            sclkPrev;
  logic            sclkRise;
  logic            csActive;
  ctlT             ctl;
  logic [HDR_W-1:0] hdr;

  assign rawIn = {sdi, csN, sclk};

  for (genvar g = 0; g < NSIG; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{SYNC_RST[g]}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= syncOut[0];
  end

  assign sclkRise = syncOut[0] & ~sclkPrev;
  assign csActive = ~syncOut[1];
  assign sdoOe    = csActive;

  spiRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .sclkRise(sclkRise),
    .hdr(hdr), .ctl(ctl)
  );

  spiRegDp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdiS(syncOut[2]),
    .regRdData(regRdData), .rxData(rxData), .hdr(hdr), .sdo(sdo),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .cmdStrobe(cmdStrobe), .txPush(txPush), .txData(txData), .rxPop(rxPop)
  );
endmodule

// File: rtl/spiRegSlaveChk.sv
module spiRegSlaveChk
  import spiRegPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  csN,
  input logic                  sdoOe,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  regWrEn,
  input logic [NUM_STROBE-1:0] cmdStrobe,
  input logic                  txPush,
  input logic                  rxPop
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(cmdStrobe)); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN) (|cmdStrobe) |=> !(|cmdStrobe)); // R4
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN) regWrEn |=> !regWrEn); // R2
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (int'(regAddr) >= REG_BASE && int'(regAddr) < REG_BASE + NUM_REGS)); // R11
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN) txPush |=> !txPush); // R5
  AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rstN) rxPop |=> !rxPop); // R6
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rstN) !(regWrEn && txPush)); // R7
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !sdoOe); // R9
endmodule

bind spiRegSlave spiRegSlaveChk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoOe(sdoOe), .regAddr(regAddr),
  .regWrEn(regWrEn), .cmdStrobe(cmdStrobe), .txPush(txPush), .rxPop(rxPop)
);

// File: tb/spiRegSlave_tb.sv
module spiRegSlave_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, sdi = 1'b0;
  logic sdo, sdoOe, regWrEn, txPush, rxPop;
  logic [5:0] regAddr;
  logic [15:0] regWrData, regRdData;
  logic [14:0] cmdStrobe;
  logic [7:0] txData, rxData;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [5:0] a; logic [15:0] d; } wrT;
  wrT expWr[$];
  int expStb[$];
  logic [7:0] expPush[$];
  logic [7:0] rxQ[$];
  int expPops = 0;
  logic [15:0] hostRegs [64];
  logic [15:0] refRegs [64];
  int csHi = 0, csLo = 0;

  always #2 clk = ~clk;

  assign regRdData = hostRegs[regAddr];
  assign rxData = (rxQ.size() > 0) ? rxQ[0] : 8'h00;

  spiRegSlave u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .sdo(sdo),
    .sdoOe(sdoOe), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cmdStrobe(cmdStrobe), .txPush(txPush),
    .txData(txData), .rxPop(rxPop), .rxData(rxData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference monitor: every clock, events must match the expected queues
  always @(negedge clk) if (rstN) begin
    if (regWrEn) begin
      if (expWr.size() == 0) chk(0, "R2", "unexpected regWrEn addr", 32'(regAddr), 0);
      else begin
        chk(regAddr == expWr[0].a, "R2", "write address", 32'(regAddr), 32'(expWr[0].a));
        chk(regWrData == expWr[0].d, "R2", "write data", 32'(regWrData), 32'(expWr[0].d));
        void'(expWr.pop_front());
      end
      hostRegs[regAddr] = regWrData;
    end
    if (cmdStrobe != 0) begin
      if (expStb.size() == 0) chk(0, "R4", "unexpected strobe", 32'(cmdStrobe), 0);
      else begin
        chk(cmdStrobe == (15'd1 << expStb[0]), "R4", "strobe vector", 32'(cmdStrobe),
            32'(15'd1 << expStb[0]));
        void'(expStb.pop_front());
      end
    end
    if (txPush) begin
      if (expPush.size() == 0) chk(0, "R5", "unexpected push", 32'(txData), 0);
      else begin
        chk(txData == expPush[0], "R5", "push byte", 32'(txData), 32'(expPush[0]));
        void'(expPush.pop_front());
      end
    end
    if (rxPop) begin
      chk(expPops > 0, "R6", "unexpected pop", 1, 0);
      if (expPops > 0) expPops--;
      if (rxQ.size() > 0) void'(rxQ.pop_front());
    end
    if (csN) begin csHi++; csLo = 0; end else begin csLo++; csHi = 0; end
    if (csHi >= 3) chk(!sdoOe, "R9", "sdoOe with cs high", 32'(sdoOe), 0);
    if (csLo >= 3) chk(sdoOe, "R9", "sdoOe with cs low", 32'(sdoOe), 1);
  end

  localparam time HALF = 20ns;

  task automatic bitXfer(input logic b, output logic so);
    sdi = b;
    #(HALF);
    so = sdo;
    sclk = 1'b1;
    #(HALF);
    sclk = 1'b0;
  endtask

  // Sends hdr then nData bits of wData; checks read bits when chkRd
  task automatic frame(input logic [7:0] hdr, input int nData, input logic [15:0] wData,
                       input bit chkRd, input logic [15:0] expRd, input string req);
    logic so;
    for (int i = 7; i >= 0; i--) bitXfer(hdr[i], so);
    for (int i = nData - 1; i >= 0; i--) begin
      bitXfer(wData[i], so);
      if (chkRd) chk(so == expRd[i], req, $sformatf("read bit %0d of addr %0h", i, hdr[5:0]),
                     32'(so), 32'(expRd[i]));
    end
  endtask

  task automatic csLow(); csN = 1'b0; #(8ns); endtask
  task automatic csHigh(); #(20ns); csN = 1'b1; #(40ns); endtask

  task automatic wrReg(input logic [5:0] a, input logic [15:0] d);
    expWr.push_back('{a, d});
    refRegs[a] = d;
    frame({2'b00, a}, 16, d, 0, 0, "R2");
  endtask

  task automatic drain(input string req);
    #(40ns);
    chk(expWr.size() == 0, req, "pending writes", 32'(expWr.size()), 0);
    chk(expStb.size() == 0, req, "pending strobes", 32'(expStb.size()), 0);
    chk(expPush.size() == 0, req, "pending pushes", 32'(expPush.size()), 0);
    chk(expPops == 0, req, "pending pops", 32'(expPops), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      hostRegs[i] = 16'(i * 16'h0101) ^ 16'hA5A5;
      refRegs[i] = hostRegs[i];
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!sdoOe && !regWrEn && !txPush && !rxPop && cmdStrobe == 0, "R9",
        "outputs in reset", {sdoOe, regWrEn, txPush, rxPop}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;

    // R1 R2 R3: single write then read back
    csLow(); wrReg(6'h12, 16'hBEEF); csHigh(); drain("R2");
    csLow(); frame(8'h52, 16, 0, 1, refRegs[6'h12], "R3"); csHigh();
    csLow(); frame(8'h70, 16, 0, 1, refRegs[6'h30], "R3"); csHigh(); drain("R1");

    // R7 chained accesses of mixed length inside one chip select
    rxQ.push_back(8'hC3);
    csLow();
    wrReg(6'h10, 16'h1234);
    expStb.push_back(3); frame(8'h03, 0, 0, 0, 0, "R4");
    expPush.push_back(8'h5A); frame(8'h3E, 8, 16'h005A, 0, 0, "R5");
    expPops++; frame(8'h7F, 8, 0, 1, 16'h00C3, "R6");
    frame(8'h50, 16, 0, 1, 16'h1234, "R7");
    wrReg(6'h30, 16'h8001);
    csHigh(); drain("R7");

    // R4 strobe with read direction at top strobe address
    csLow(); expStb.push_back(14); frame(8'h4E, 0, 0, 0, 0, "R4");
    expStb.push_back(0); frame(8'h00, 0, 0, 0, 0, "R4"); csHigh(); drain("R4");

    // R8 abort mid-write, then read the register back
    csLow(); frame(8'h20, 10, 16'h3FF, 0, 0, "R8"); csHigh();
    csLow(); frame(8'h60, 16, 0, 1, refRegs[6'h20], "R8"); csHigh();
    csLow(); frame(8'h3E, 5, 16'h1F, 0, 0, "R8"); csHigh(); drain("R8");

    // R10 RAM select header: following bits look like a write and a strobe
    csLow(); frame(8'h91, 16, 16'hFFFF, 0, 0, "R10");
    frame(8'h11, 16, 16'h0F0F, 0, 0, "R10"); frame(8'h05, 0, 0, 0, 0, "R10"); csHigh();
    csLow(); frame(8'h51, 16, 0, 1, refRegs[6'h11], "R10"); csHigh(); drain("R10");

    // R11 unused addresses and wrong-direction FIFO ports
    rxQ.push_back(8'h77);
    csLow();
    frame(8'h0F, 16, 16'hDEAD, 0, 0, "R11");
    frame(8'h31, 16, 16'hCAFE, 0, 0, "R11");
    frame(8'h71, 16, 0, 1, 16'h0000, "R11");
    frame(8'h4F, 16, 0, 1, 16'h0000, "R11");
    frame(8'h7E, 8, 0, 1, 16'h0000, "R11");
    frame(8'h3F, 8, 16'h00AA, 0, 0, "R11");
    frame(8'h4F, 16, 0, 1, 16'h0000, "R11");
    csHigh(); drain("R11");
    chk(rxQ.size() == 1, "R11", "rx fifo untouched", 32'(rxQ.size()), 1);
    chk(hostRegs[6'h0F] == refRegs[6'h0F], "R11", "no write at 0x0F", 32'(hostRegs[6'h0F]),
        32'(refRegs[6'h0F]));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(400us);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule